// File: doc/BRIEF.md
# MX block quantizer

This block turns a stream of 32 single-precision values into one microscaling block: a shared 8-bit power-of-two scale (exponent only, bias 127) followed by 32 narrow element codes. A per-block format input selects between an 8-bit element (1 sign, 4 exponent, 3 mantissa bits) and a 4-bit element (1 sign, 2 exponent, 1 mantissa bit). Values arrive one per cycle under a valid/ready handshake. The block stores the whole group and tracks the largest exponent while loading. It then derives the scale and writes a byte stream: the scale byte, then the element codes in input order.

The scale makes the largest element land on the top binade of the chosen element format. Each element is divided by the scale, rounded to nearest with ties to even, and clamped to the largest finite code. A group that holds an input with an all-ones exponent field is flagged through the reserved scale code. Subnormal inputs are not supported. An exponent field of zero is treated as zero.

Top module: `mx_quantizer`

## Requirements
- R1: inReady is high while a group is loading. Each cycle with inValid and inReady both high accepts one element, and a cycle with inValid low accepts nothing. inReady is low in the cycle after the 32nd accept and stays low until the last output byte of that group is on outData.
- R2: After reset, outValid is 0 and inReady is 1.
- R3: The format is sampled with element 0 only: fmtSel 0 is the 8-bit format (top exponent 8) and fmtSel 1 is the 4-bit format (top exponent 2). The scale byte equals the largest input exponent field minus the top exponent, clamped to 0..254.
- R4: A group whose inputs all have exponent field 0 gives scale byte 0x00 and all element codes 0, whatever the sign bits.
- R5: If any input has exponent field 0xFF, the scale byte is 0xFF and every element byte of that group is 0x00.
- R6: An element is the input times 2^(127 - scale), rounded to nearest with ties to the even code. In the 8-bit format the sign is in bit 7, the exponent (bias 7) in bits 6:3 and the mantissa in bits 2:0, and exponent 0 means mantissa times 2^-9. In the 4-bit format the sign is in bit 3, the exponent (bias 1) in bits 2:1 and the mantissa in bit 0, and exponent 0 means mantissa times 0.5.
- R7: A magnitude above the largest finite value saturates to magnitude code 0x7E (448) in the 8-bit format or 0x7 (6.0) in the 4-bit format, with the sign kept. The code 0x7F never appears in the 8-bit format.
- R8: The output is one unbroken run of outValid: 33 bytes in the 8-bit format and 17 in the 4-bit format. The scale comes first, then the elements in input order. In the 4-bit format the lower-index element of each pair is in the low nibble.
- R9: An element whose rounded magnitude is zero is coded as all zeros, never as a negative zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input element present |
| inReady | output | 1 | Block can accept an element |
| inData | input | 32 | Single-precision input value |
| fmtSel | input | 1 | Element format, sampled with element 0 (0: 8-bit, 1: 4-bit) |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Scale byte or packed element codes |

## Verification
Two events share a cycle. The last output byte of one group is on the port in the same cycle that inReady rises and element 0 of the next group is accepted, and that acceptance captures the new format. The bench provokes this by queueing the next group while the previous one is still emitting and by switching the format between groups. It judges the result by the scoreboard's byte-exact match on both groups. A second case puts the outlier or the NaN on the last element, so that the final exponent update must reach the scale byte. fmtSel is also toggled on elements 1..31 to show that only element 0 selects the format.

// File: rtl/mxq_pkg.sv
`timescale 1ns/1ps
package mxq_pkg;
  localparam int MXQ_BLOCK = 32;
  localparam int MXQ_IDX_W = $clog2(MXQ_BLOCK);
  localparam int MXQ_FP_W  = 32;
  localparam int MXQ_LANES = 2;

  typedef enum logic {FMT_E4M3 = 1'b0, FMT_E2M1 = 1'b1} mxFmt_e;

  typedef struct packed {
    logic                 load;
    logic                 first;
    logic [MXQ_IDX_W-1:0] wrIdx;
    logic                 emit;
    logic [MXQ_IDX_W:0]   emitIdx;
  } mxqStrobe_t;

  function automatic int fmtEmax(mxFmt_e f);
    return (f == FMT_E2M1) ? 2 : 8;
  endfunction
  function automatic int fmtEmin(mxFmt_e f);
    return (f == FMT_E2M1) ? 0 : -6;
  endfunction
  function automatic int fmtMant(mxFmt_e f);
    return (f == FMT_E2M1) ? 1 : 3;
  endfunction
  function automatic int fmtMaxCode(mxFmt_e f);
    return (f == FMT_E2M1) ? 7 : 126;
  endfunction
  function automatic int fmtSignPos(mxFmt_e f);
    return (f == FMT_E2M1) ? 3 : 7;
  endfunction
endpackage

// File: rtl/mxq_ctrl.sv
`timescale 1ns/1ps
module mxq_ctrl
  import mxq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  mxFmt_e     fmtQ,
  output logic       inReady,
  output mxqStrobe_t strobe
);
  typedef enum logic {ST_LOAD, ST_EMIT} state_e;
  localparam logic [MXQ_IDX_W:0] LAST_LOAD = (MXQ_IDX_W+1)'(MXQ_BLOCK - 1);
  localparam logic [MXQ_IDX_W:0] LAST_WIDE = (MXQ_IDX_W+1)'(MXQ_BLOCK);
  localparam logic [MXQ_IDX_W:0] LAST_NARW = (MXQ_IDX_W+1)'(MXQ_BLOCK / 2);

  state_e state;
  logic [MXQ_IDX_W:0] cnt;
  logic [MXQ_IDX_W:0] lastEmit;
  logic accept;

  assign lastEmit = (fmtQ == FMT_E2M1) ? LAST_NARW : LAST_WIDE;
  assign inReady  = (state == ST_LOAD);
  assign accept   = inReady && inValid;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.first   = accept && (cnt == '0);
    strobe.wrIdx   = cnt[MXQ_IDX_W-1:0];
    strobe.emit    = (state == ST_EMIT);
    strobe.emitIdx = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else if (state == ST_LOAD) begin
      if (accept) begin
        if (cnt == LAST_LOAD) begin
          state <= ST_EMIT;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      if (cnt == lastEmit) begin
        state <= ST_LOAD;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mxq_datapath.sv
`timescale 1ns/1ps
module mxq_datapath
  import mxq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  mxqStrobe_t          strobe,
  input  logic [MXQ_FP_W-1:0] inData,
  input  logic                fmtSel,
  output mxFmt_e              fmtQ,
  output logic                outValid,
  output logic [7:0]          outData
);
  logic [MXQ_FP_W-1:0] groupMem [MXQ_BLOCK];
  logic [7:0] maxExp;
  logic       nanSeen;
  logic [7:0] scaleByte;
  logic [7:0] laneCode [MXQ_LANES];
  logic [7:0] inExp;

  assign inExp = inData[30:23];

  function automatic logic [7:0] quantElem(logic [MXQ_FP_W-1:0] x, logic [7:0] scl, mxFmt_e f);
    logic [31:0] sig;
    logic [31:0] q;
    logic [31:0] gbit;
    logic sticky;
    int u, ue, s, code;
    logic [7:0] r;
    sig = {8'd0, 1'b1, x[22:0]};
    u   = int'(x[30:23]) - int'(scl);
    ue  = (u < fmtEmin(f)) ? fmtEmin(f) : u;
    s   = 23 - fmtMant(f) + (ue - u);
    if (s > 25) s = 25;
    q      = sig >> s;
    gbit   = (sig >> (s - 1)) & 32'd1;
    sticky = (sig & ((32'd1 << (s - 1)) - 32'd1)) != 32'd0;
    if (gbit[0] && (sticky || q[0])) q = q + 32'd1;
    code = ((ue - fmtEmin(f)) << fmtMant(f)) + int'(q);
    if (q == 32'd0) code = 0;
    if (code > fmtMaxCode(f)) code = fmtMaxCode(f);
    if (x[30:23] == 8'd0) code = 0;
    r = 8'(code);
    if (code != 0 && x[31]) r = r | (8'd1 << fmtSignPos(f));
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.load) groupMem[strobe.wrIdx] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxExp  <= '0;
      nanSeen <= 1'b0;
      fmtQ    <= FMT_E4M3;
    end else if (strobe.load) begin
      if (strobe.first) begin
        fmtQ    <= mxFmt_e'(fmtSel);
        maxExp  <= (inExp == 8'hFF) ? 8'd0 : inExp;
        nanSeen <= (inExp == 8'hFF);
      end else begin
        if (inExp != 8'hFF && inExp > maxExp) maxExp <= inExp;
        if (inExp == 8'hFF) nanSeen <= 1'b1;
      end
    end
  end

  always_comb begin
    int sc;
    sc = int'(maxExp) - fmtEmax(fmtQ);
    if (sc < 0) sc = 0;
    if (sc > 254) sc = 254;
    scaleByte = nanSeen ? 8'hFF : 8'(sc);
  end

  for (genvar ln = 0; ln < MXQ_LANES; ln++) begin : g_lane
    logic [MXQ_IDX_W-1:0] rdIdx;
    always_comb begin
      int ri;
      ri = (fmtQ == FMT_E2M1) ? (2 * (int'(strobe.emitIdx) - 1) + ln)
                              : (int'(strobe.emitIdx) - 1);
      if (ri < 0) ri = 0;
      rdIdx = MXQ_IDX_W'(ri);
    end
    assign laneCode[ln] = quantElem(groupMem[rdIdx], scaleByte, fmtQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        if (strobe.emitIdx == '0)   outData <= scaleByte;
        else if (nanSeen)           outData <= 8'h00;
        else if (fmtQ == FMT_E2M1)  outData <= {laneCode[1][3:0], laneCode[0][3:0]};
        else                        outData <= laneCode[0];
      end
    end
  end
endmodule

// File: rtl/mx_quantizer.sv
`timescale 1ns/1ps
module mx_quantizer
  import mxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic        fmtSel,
  output logic        outValid,
  output logic [7:0]  outData
);
  mxqStrobe_t strobe;
  mxFmt_e     fmtQ;

  mxq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtQ(fmtQ),
    .inReady(inReady), .strobe(strobe)
  );

  mxq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .fmtSel(fmtSel),
    .fmtQ(fmtQ), .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/mx_quantizer_chk.sv
`timescale 1ns/1ps
module mx_quantizer_chk
  import mxq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       fmtSel,
  input logic       outValid,
  input logic [7:0] outData
);
  logic [MXQ_IDX_W-1:0] accCnt;
  logic [MXQ_IDX_W:0]   outCnt;
  logic accFmt, outFmt, curFmt, nanBlk, lastSeen;
  logic [MXQ_IDX_W:0] totLast;

  assign curFmt  = (outCnt == '0) ? accFmt : outFmt;
  assign totLast = curFmt ? (MXQ_IDX_W+1)'(MXQ_BLOCK / 2) : (MXQ_IDX_W+1)'(MXQ_BLOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCnt <= '0; outCnt <= '0; accFmt <= 1'b0; outFmt <= 1'b0;
      nanBlk <= 1'b0; lastSeen <= 1'b0;
    end else begin
      if (inValid && inReady) begin
        accCnt <= accCnt + 1'b1;
        if (accCnt == '0) accFmt <= fmtSel;
      end
      lastSeen <= outValid && (outCnt == totLast);
      if (outValid) begin
        if (outCnt == '0) begin
          outFmt <= accFmt;
          nanBlk <= (outData == 8'hFF);
        end
        outCnt <= (outCnt == totLast) ? '0 : outCnt + 1'b1;
      end
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && accCnt == (MXQ_IDX_W)'(MXQ_BLOCK - 1)) |=> !inReady);

  a_r8_burst_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> lastSeen);

  a_r5_nan_elements_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCnt != '0 && nanBlk) |-> (outData == 8'h00));

  a_r7_no_nan_code: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCnt != '0 && !outFmt) |-> (outData[6:0] != 7'h7F || nanBlk));

  a_r9_no_neg_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCnt != '0) |->
      (outFmt ? (outData[3:0] != 4'h8 && outData[7:4] != 4'h8) : (outData != 8'h80)));
endmodule

bind mx_quantizer mx_quantizer_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .fmtSel(fmtSel),
  .outValid(outValid), .outData(outData)
);

// File: tb/mx_quantizer_tb.sv
`timescale 1ns/1ps
module mx_quantizer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] inData = '0;
  logic fmtSel = 1'b0;
  logic outValid;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [31:0] blk [32];

  always #2.5 clk = ~clk;

  mx_quantizer u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .fmtSel(fmtSel), .outValid(outValid), .outData(outData)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic real decodeCode(int c, bit f);
    int e, m;
    if (f) begin
      e = c >> 1; m = c & 1;
      return (e == 0) ? real'(m) * 0.5 : (1.0 + real'(m) / 2.0) * (2.0 ** real'(e - 1));
    end
    e = c >> 3; m = c & 7;
    return (e == 0) ? real'(m) / 512.0 : (1.0 + real'(m) / 8.0) * (2.0 ** real'(e - 7));
  endfunction

  function automatic logic [7:0] refElem(logic [31:0] x, int sc, bit f);
    real y, d, best;
    int bc, maxc;
    if (x[30:23] == 8'd0) return 8'h00;
    y = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** real'(int'(x[30:23]) - sc));
    maxc = f ? 7 : 126;
    best = 1.0e300; bc = 0;
    for (int c = 0; c <= maxc; c++) begin
      d = decodeCode(c, f) - y;
      if (d < 0.0) d = -d;
      if (d < best || (d == best && (c % 2) == 0)) begin best = d; bc = c; end
    end
    if (bc == 0) return 8'h00;
    return 8'(bc) | (x[31] ? (f ? 8'h08 : 8'h80) : 8'h00);
  endfunction

  task automatic pushExpected(bit f);
    int mx, sc;
    bit nan;
    logic [7:0] e0, e1;
    mx = 0; nan = 0;
    for (int i = 0; i < 32; i++) begin
      if (blk[i][30:23] == 8'hFF) nan = 1;
      else if (int'(blk[i][30:23]) > mx) mx = int'(blk[i][30:23]);
    end
    sc = mx - (f ? 2 : 8);
    if (sc < 0) sc = 0;
    expQ.push_back(nan ? 8'hFF : 8'(sc));
    tagQ.push_back(nan ? "R5 scale" : "R3 scale");
    if (f) begin
      for (int k = 0; k < 16; k++) begin
        e0 = nan ? 8'h00 : refElem(blk[2*k], sc, 1'b1);
        e1 = nan ? 8'h00 : refElem(blk[2*k+1], sc, 1'b1);
        expQ.push_back({e1[3:0], e0[3:0]});
        tagQ.push_back("R6/R8 packed pair");
      end
    end else begin
      for (int k = 0; k < 32; k++) begin
        expQ.push_back(nan ? 8'h00 : refElem(blk[k], sc, 1'b0));
        tagQ.push_back("R6/R7 element");
      end
    end
  endtask

  // drives one group; called at a negedge, returns at a negedge
  task automatic sendBlock(bit f, bit gaps);
    pushExpected(f);
    for (int i = 0; i < 32; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        inValid = 1'b0;
        inData  = 32'h7FC0_0000; // R1: idle cycle with a NaN on the bus must be ignored
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = blk[i];
      fmtSel  = (i == 0) ? f : ~f; // R3: only element 0 selects the format
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    check(inReady == 1'b0, "R1 ready low after 32nd accept", 32'(inReady), 32'd0);
  endtask

  function automatic logic [31:0] rndVal(int eLo, int eHi);
    logic [31:0] v;
    v[31]    = 1'($urandom_range(0, 1));
    v[30:23] = 8'($urandom_range(eLo, eHi));
    v[22:0]  = 23'($urandom);
    if ($urandom_range(0, 7) == 0) v[30:0] = '0;
    return v;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected output byte", 32'(outData), 32'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData == e, t, 32'(outData), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R2 outValid in reset", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R2 inReady in reset", 32'(inReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R2 outValid after reset", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R2 inReady after reset", 32'(inReady), 32'd1);

    // random groups, both formats, with and without gaps
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 32; i++) blk[i] = rndVal(118, 134);
      sendBlock(b[0], b[1]);
    end

    // outlier on the last element (8-bit), then on the first (4-bit): R3, R6
    for (int i = 0; i < 32; i++) blk[i] = rndVal(125, 135);
    blk[31] = 32'h4600_0000 | (32'(140) << 23) & 32'h7F80_0000;
    blk[31] = {1'b0, 8'd140, 23'h123456};
    sendBlock(1'b0, 1'b0);
    for (int i = 0; i < 32; i++) blk[i] = rndVal(120, 130);
    blk[0] = {1'b1, 8'd138, 23'h000000};
    sendBlock(1'b1, 1'b0);

    // R4/R9: all zero, including negative zeros
    for (int i = 0; i < 32; i++) blk[i] = {1'(i & 1), 31'd0};
    sendBlock(1'b0, 1'b0);
    sendBlock(1'b1, 1'b0);

    // R5: NaN on the last element, infinity in the middle
    for (int i = 0; i < 32; i++) blk[i] = rndVal(120, 130);
    blk[31] = 32'h7FC0_0001;
    sendBlock(1'b0, 1'b0);
    for (int i = 0; i < 32; i++) blk[i] = rndVal(120, 130);
    blk[5] = 32'hFF80_0000;
    sendBlock(1'b1, 1'b0);

    // R3: scale clamped at zero
    for (int i = 0; i < 32; i++) blk[i] = rndVal(1, 6);
    sendBlock(1'b0, 1'b0);

    // R7: all at the top binade with full mantissa -> saturation
    for (int i = 0; i < 32; i++) blk[i] = {1'(i & 1), 8'd130, 23'h7FFFFF};
    sendBlock(1'b0, 1'b0);
    sendBlock(1'b1, 1'b0);

    // R6: exact ties; element 0 fixes the scale at 127
    for (int i = 0; i < 32; i++) blk[i] = {1'b0, 8'd127, 23'h080000};
    blk[0] = {1'b0, 8'd135, 23'h0};
    blk[1] = {1'b0, 8'd127, 23'h180000};
    blk[2] = {1'b1, 8'd127, 23'h080000};
    sendBlock(1'b0, 1'b0);
    for (int i = 0; i < 32; i++) blk[i] = {1'b0, 8'd127, 23'h200000};
    blk[0] = {1'b0, 8'd129, 23'h0};
    blk[1] = {1'b0, 8'd127, 23'h600000};
    blk[3] = {1'b1, 8'd127, 23'h600000};
    sendBlock(1'b1, 1'b0);

    // drain
    for (int w = 0; w < 200 && expQ.size() != 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 all expected bytes emitted", 32'(expQ.size()), 32'd0);
    check(outValid == 1'b0, "R8 output idle after drain", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R1 ready after drain", 32'(inReady), 32'd1);
    finishRun();
  end
endmodule